// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM Front End

This block is the clocked front end of a small synchronous SRAM with a flow-through read path. Address, write data, the three chip enables, both address strobes, the advance input and all write enables are registered on the rising clock edge. Either of two address strobes can load a start address. A 2-bit burst counter then walks the other three words of the aligned four-word block. A level input selects the walk order: interleaved (exclusive-OR) or linear (wrapping increment).

Reads need no output register. The registered burst address drives the array, so the addressed word reaches the data output in the cycle right after the edge that registered it, which gives a 2-1-1-1 burst. Writes can cover a whole word through the global write input, or single 9-bit lanes through the byte write enable and the per-lane enables. Output enable gates the read data combinationally. The array holds 16 words of 36 bits by default.

Top module: `burst_sram`

## Requirements
- R1: During and right after reset the chip is deselected and `rdData` is all zeros.
- R2: A low `adscN` loads `addr` as the start address and clears the burst count, whatever the level of `ce1N`. When `adscN` and `adspN` are both low, the controller strobe wins and the edge is handled as a controller load.
- R3: A low `adspN` loads only when `ce1N` is low. With `ce1N` high it is ignored, and the burst address and chip selection stay as they were.
- R4: At a load the chip is selected only if `ce1N`=0, `ce2`=1 and `ce3N`=0. While deselected, `rdData` is zero and no write changes the array.
- R5: With `burstMode`=1 (interleaved), the low two address bits equal the start low bits XOR the burst count.
- R6: With `burstMode`=0 (linear), the low two address bits equal the start low bits plus the count, modulo 4. In both orders the upper address bits never change during a burst, so the fifth beat returns to the start word.
- R7: On an edge with no load, the count steps by one if `advN` is low and holds if `advN` is high.
- R8: Reads are flow-through. After the edge that registers an address, the word at that address appears on `rdData` within the same cycle.
- R9: `gwN`=0 writes all four lanes with `wrData`. Lane i occupies bits 9i+8 down to 9i.
- R10: With `gwN`=1 and `bweN`=0, only the lanes whose `bwN[i]` is 0 are written. With `gwN`=1 and `bweN`=1, nothing is written, whatever `bwN` holds.
- R11: An edge that loads through `adspN` never writes, even when write enables are asserted.
- R12: `oeN`=1 forces `rdData` to zero at once, without waiting for a clock edge. `oeN`=0 restores the read data.
- R13: A controller-strobe load with a write enabled writes `wrData` to the address presented on that edge. A write on a non-load edge goes to the current burst address, and the counter then advances if `advN` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Start address, used on load edges |
| wrData | input | LANES*LANE_W | Write data |
| ce1N | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Depth-expansion enable, active high |
| ce3N | input | 1 | Depth-expansion enable, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| bweN | input | 1 | Byte write enable, active low |
| bwN | input | LANES | Per-lane write enables, active low |
| gwN | input | 1 | Global write, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| burstMode | input | 1 | 1 = interleaved order, 0 = linear order |
| rdData | output | LANES*LANE_W | Flow-through read data, zero when gated |

## Verification
The bench runs every start offset in both orders and takes the burst one beat past the fourth word. A counter that carries into the upper address bits, or that mixes up the XOR and add rules, then reads a word from the wrong block or in the wrong sequence. It asserts both strobes together with a write enabled, so a design that gives the processor strobe priority drops the write. It also pulses the processor strobe with CE1 high, where a design without that gate jumps to a new address. Lane merges check that a wrong lane mapping or a write on a processor-strobe load corrupts stored bytes. The bench also checks a write attempt while the chip is deselected, and an output-enable toggle in the middle of a cycle, which an output enable that waits for a clock edge would miss.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BURST_W = 2;
  localparam int BURST_LEN = 1 << BURST_W;

  typedef struct packed {
    logic wrEn;
    logic rdSel;
  } memStrobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              gwN,
  input  logic              burstMode,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LANES-1:0]  laneMask
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              loadCtl, loadProc, loadAny;
  logic              csIn, wrReq;
  logic [ADDR_W-1:0] startQ;
  logic [BURST_W-1:0] cntQ, burstLow;
  logic              selQ;
  logic [ADDR_W-1:0] curAddr;

  assign loadCtl  = !adscN;
  assign loadProc = adscN && !adspN && !ce1N;
  assign loadAny  = loadCtl || loadProc;
  assign csIn     = !ce1N && ce2 && !ce3N;
  assign wrReq    = !gwN || (!bweN && !(&bwN));

  always_comb begin
    if (!gwN)       laneMask = '1;
    else if (!bweN) laneMask = ~bwN;
    else            laneMask = '0;
  end

  always_comb begin
    if (burstMode) burstLow = startQ[BURST_W-1:0] ^ cntQ;
    else           burstLow = startQ[BURST_W-1:0] + cntQ;
  end

  assign curAddr = {startQ[ADDR_W-1 -: HI_W], burstLow};
  assign rdAddr  = curAddr;

  always_comb begin
    strobe.rdSel = selQ;
    if (loadCtl) begin
      strobe.wrEn = csIn && wrReq;
      wrAddr      = addr;
    end else if (loadProc) begin
      strobe.wrEn = 1'b0;
      wrAddr      = curAddr;
    end else begin
      strobe.wrEn = selQ && wrReq;
      wrAddr      = curAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      cntQ   <= '0;
      selQ   <= 1'b0;
    end else if (loadAny) begin
      startQ <= addr;
      cntQ   <= '0;
      selQ   <= csIn;
    end else if (!advN) begin
      cntQ   <= cntQ + 1'b1;
    end
  end

  p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    !adscN |=> (cntQ == '0) && (startQ == $past(addr)));

  p_proc_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (adscN && !adspN && ce1N) |=> $stable(startQ) && $stable(selQ));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (adscN && (adspN || ce1N) && advN) |=> $stable(cntQ));

  p_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (adscN && (adspN || ce1N) && !advN) |=> cntQ == $past(cntQ) + 2'd1);

  p_same_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (adscN && (adspN || ce1N)) |=>
      rdAddr[ADDR_W-1 -: HI_W] == $past(rdAddr[ADDR_W-1 -: HI_W]));

  p_proc_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (adscN && !adspN && !ce1N) |-> !strobe.wrEn);
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  memStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (strobe.wrEn && laneMask[g])
        mem[wrAddr][g*LANE_W +: LANE_W] <= wrData[g*LANE_W +: LANE_W];
    end

    p_lane_write_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && laneMask[g]) |=>
        mem[$past(wrAddr)][g*LANE_W +: LANE_W] === $past(wrData[g*LANE_W +: LANE_W]));

    p_lane_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.wrEn && laneMask[g]) |=>
        mem[$past(wrAddr)][g*LANE_W +: LANE_W] === $past(mem[wrAddr][g*LANE_W +: LANE_W]));
  end

  assign rdData = (strobe.rdSel && !oeN) ? mem[rdAddr] : '0;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    adspN,
  input  logic                    adscN,
  input  logic                    advN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    gwN,
  input  logic                    oeN,
  input  logic                    burstMode,
  output logic [LANES*LANE_W-1:0] rdData
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [LANES-1:0]  laneMask;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .bweN(bweN), .bwN(bwN),
    .gwN(gwN), .burstMode(burstMode), .strobe(strobe), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .laneMask(laneMask)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .laneMask(laneMask), .wrData(wrData), .oeN(oeN), .rdData(rdData)
  );

  p_oe_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> rdData == '0);
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  // {mode, start low bits, beat0..beat3 low bits}
  localparam logic [10:0] VEC [8] = '{
    11'b1_00_00_01_10_11, 11'b1_01_01_00_11_10,
    11'b1_10_10_11_00_01, 11'b1_11_11_10_01_00,
    11'b0_00_00_01_10_11, 11'b0_01_01_10_11_00,
    11'b0_10_10_11_00_01, 11'b0_11_11_00_01_10
  };

  logic clk = 0;
  logic rstN = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic ce1N = 0, ce2 = 1, ce3N = 0;
  logic adspN = 1, adscN = 1, advN = 1;
  logic bweN = 1, gwN = 1, oeN = 0, burstMode = 0;
  logic [LANES-1:0] bwN = '1;
  logic [DW-1:0] rdData;

  logic [DW-1:0] model [1 << ADDR_W];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_sram u_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .ce1N(ce1N),
    .ce2(ce2), .ce3N(ce3N), .adspN(adspN), .adscN(adscN), .advN(advN),
    .bweN(bweN), .bwN(bwN), .gwN(gwN), .oeN(oeN), .burstMode(burstMode),
    .rdData(rdData)
  );

  function automatic logic [DW-1:0] pat(int a);
    return {9'(a + 400), 9'(a + 300), 9'(a + 200), 9'(a + 100)};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    adspN = 1; adscN = 1; advN = 1; gwN = 1; bweN = 1; bwN = '1;
    ce1N = 0; ce2 = 1; ce3N = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] tmp;
    logic [ADDR_W-1:0] lastA;
    step(); step();
    chk("R1 reset", rdData, '0);
    rstN = 1;
    step();
    chk("R1 after reset", rdData, '0);

    // Preload every word with a controller-strobe global write
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      idle(); adscN = 0; gwN = 0; addr = ADDR_W'(a); wrData = pat(a);
      model[a] = pat(a);
      step();
      chk("R9 full write", rdData, model[a]);
    end
    idle();

    // Burst order table: block 4..7, every offset, both orders
    lastA = '0;
    for (int v = 0; v < 8; v++) begin
      logic [ADDR_W-1:0] base, ea;
      string ord;
      base = 4'd4;
      ord = VEC[v][10] ? "R5" : "R6";
      burstMode = VEC[v][10];
      idle(); adspN = 0; addr = base | ADDR_W'(VEC[v][9:8]);
      step();
      ea = base | ADDR_W'(VEC[v][7:6]);
      chk("R8 first beat", rdData, model[ea]);
      idle();
      for (int k = 1; k < 4; k++) begin
        advN = 0;
        step();
        ea = base | ADDR_W'(VEC[v][7-2*k -: 2]);
        chk(ord, rdData, model[ea]);
      end
      step();
      ea = base | ADDR_W'(VEC[v][9:8]);
      chk("R6 wrap to start", rdData, model[ea]);
      advN = 1;
      step();
      chk("R7 hold", rdData, model[ea]);
      lastA = ea;
    end

    // R3: processor strobe with ce1N high is ignored
    idle(); adspN = 0; ce1N = 1; addr = 4'd9;
    step();
    chk("R3 ignored strobe", rdData, model[lastA]);

    // R2: both strobes plus write, controller wins and writes
    idle(); adscN = 0; adspN = 0; gwN = 0; addr = 4'd2; wrData = 36'hABCD1234E;
    model[2] = 36'hABCD1234E;
    step();
    chk("R2 priority write", rdData, model[2]);

    // R4: deselect via ce2, then write attempt on non-load edge
    idle(); adscN = 0; ce2 = 0; addr = 4'd3;
    step();
    chk("R4 deselected ce2", rdData, '0);
    idle(); gwN = 0; wrData = 36'h0DEADBEEF;
    step();
    chk("R4 no read while deselected", rdData, '0);
    idle(); adscN = 0; addr = 4'd3;
    step();
    chk("R4 array untouched", rdData, model[3]);
    idle(); adscN = 0; ce3N = 1; addr = 4'd3;
    step();
    chk("R4 deselected ce3N", rdData, '0);
    idle(); adscN = 0; ce1N = 1; addr = 4'd3;
    step();
    chk("R2 loads with ce1N high, deselects", rdData, '0);

    // R11: processor load ignores write enables
    idle(); adspN = 0; gwN = 0; addr = 4'd5; wrData = 36'h1FFFFFFFF;
    step();
    chk("R11 proc load no write", rdData, model[5]);

    // R10: byte lanes 0 and 2 written
    idle(); bweN = 0; bwN = 4'b1010; wrData = 36'hFFFFFFFFF;
    tmp = model[5];
    for (int i = 0; i < LANES; i++)
      if (!bwN[i]) tmp[i*LANE_W +: LANE_W] = wrData[i*LANE_W +: LANE_W];
    model[5] = tmp;
    step();
    chk("R10 lane merge", rdData, model[5]);
    idle(); bweN = 1; bwN = '0; wrData = '0;
    step();
    chk("R10 no write without bweN", rdData, model[5]);

    // R13: write on non-load edge then advance (linear)
    idle(); burstMode = 0; gwN = 0; advN = 0; wrData = 36'h123456789;
    model[5] = 36'h123456789;
    step();
    chk("R13 advanced after write", rdData, model[6]);
    idle(); adspN = 0; addr = 4'd5;
    step();
    chk("R13 written at burst addr", rdData, model[5]);

    // R12: mid-cycle output enable toggling
    idle();
    oeN = 1; #1;
    chk("R12 gated off", rdData, '0);
    oeN = 0; #1;
    chk("R12 restored", rdData, model[5]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule